// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. It covers register-to-register arithmetic, load word, store word, branch-if-equal and jump. A single memory port carries both instruction fetches and data accesses. One ALU does all the arithmetic: it increments the PC, computes branch destinations and memory addresses, and performs the instruction's own operation.

Every value that must survive a clock edge is held in a private register. These are the instruction word, the memory data word, the two source operands, the ALU result and a branch destination. The destination register is computed early, during decode, and has its own write enable. An external sequencer drives a fresh set of control inputs every cycle. The memory sits outside the block. A write is taken at the clock edge. Read data must settle within the same cycle in which the address is presented.

Top module: `mc_datapath`

## Requirements
- R1: After reset the PC is 0, so the first address presented with `addr_sel`=0 is 0, and `mem_we` is low while `mem_wr` is low.
- R2: A fetch cycle has these controls: `addr_sel`=0, `ir_wr`=1, `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add), `pc_src`=0 (live ALU result) and `pc_wr`=1. It latches `mem_rdata` as the instruction and advances the PC by 4. The PC changes only through `pc_wr`, or through `pc_wr_cond` when the ALU result is zero.
- R3: A load word (opcode 0x23; base in bits 25:21, destination in bits 20:16, signed offset in bits 15:0) reads the word at base plus the sign-extended offset. The address is computed with `alu_a_sel`=1 and `alu_b_sel`=2. A cycle with `addr_sel`=1 captures the word. A write-back cycle with `rf_we`=1, `dst_sel`=0 and `wb_sel`=1 then writes it to the destination register. Negative offsets are honoured.
- R4: A store word (opcode 0x2B) puts the register named by bits 20:16 on `mem_wdata`. The address is base plus the sign-extended offset, presented on `mem_addr` in a cycle with `addr_sel`=1 and `mem_wr`=1.
- R5: A register-format instruction (opcode 0, sources in bits 25:21 and 20:16, destination in bits 15:11, shift amount in bits 10:6) is executed with `alu_op`=2. Its function code in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x27 NOR, 0x2A signed set-less-than, and 0x00 left shift of the second source by the shift amount. A following cycle with `rf_we`=1, `dst_sel`=1 and `wb_sel`=0 writes the result to the destination register.
- R6: Register 0 reads as zero even after an arithmetic result or a load has targeted it.
- R7: A branch-if-equal (opcode 0x04) is resolved with `alu_op`=1 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (Target). When the two registers are equal, the PC becomes the fetch PC + 4 + (sign-extended offset × 4), wrapping modulo 2^32. Otherwise it stays at fetch PC + 4.
- R8: A jump (opcode 0x02) with `pc_wr`=1 and `pc_src`=2 loads the PC with the upper four bits of the incremented PC, then bits 25:0 of the instruction, then two zero bits.
- R9: The branch destination register is loaded during decode (`alu_a_sel`=0, `alu_b_sel`=3) only when `tgt_wr` is 1. With `tgt_wr` at 0 it keeps the destination computed for an earlier instruction.
- R10: Memory is written only in cycles with `mem_wr`=1. A cycle with `addr_sel`=1 and `mem_wr`=0 leaves the addressed word unchanged.
- R11: With `pc_src`=3 and `pc_wr`=1, the PC is loaded from the registered ALU result of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when the ALU result is zero |
| tgt_wr | input | 1 | Branch destination register write |
| ir_wr | input | 1 | Instruction register write |
| addr_sel | input | 1 | Memory address: 0 PC, 1 registered ALU result |
| mem_wr | input | 1 | Memory write request |
| rf_we | input | 1 | Register file write |
| dst_sel | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write-back data: 0 registered ALU result, 1 memory data register |
| alu_a_sel | input | 1 | ALU first operand: 0 PC, 1 operand A |
| alu_b_sel | input | 2 | ALU second operand: 0 B, 1 four, 2 sign-extended offset, 3 offset × 4 |
| alu_op | input | 2 | 0 add, 1 subtract, 2 function code |
| pc_src | input | 2 | Next PC: 0 live ALU, 1 Target, 2 jump field, 3 registered ALU |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (operand B) |
| mem_we | output | 1 | Memory write strobe |

## Verification
The block has only one configurable value, the reset PC, and the bench builds it at its default of 0. The bench uses the register file at its full 32 entries. The small configuration is the operand set instead. Six 32-bit values cover zero, one, both signed extremes, all-ones and a mixed pattern. Every ordered pair of them is run through every function code, which covers signed-compare sign flips, subtract borrows and shift amounts up to 25. Branch offsets span forward, backward and the most negative value, which wraps the PC to the top of the address space. The jump that follows then shows the upper PC bits being kept.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_wr,
  input  logic        pc_wr_cond,
  input  logic        tgt_wr,
  input  logic        ir_wr,
  input  logic        addr_sel,
  input  logic        mem_wr,
  input  logic        rf_we,
  input  logic        dst_sel,
  input  logic        wb_sel,
  input  logic        alu_a_sel,
  input  logic [1:0]  alu_b_sel,
  input  logic [1:0]  alu_op,
  input  logic [1:0]  pc_src,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we
);

  logic [31:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q, tgt_q;
  logic [31:0] rf [32];

  logic [4:0]  rs, rt, rd, shamt, wa;
  logic [5:0]  funct;
  logic [31:0] imm_sx, opa, opb, alu_y, pc_next, wd;
  logic        alu_zero, pc_en;

  assign rs     = ir_q[25:21];
  assign rt     = ir_q[20:16];
  assign rd     = ir_q[15:11];
  assign shamt  = ir_q[10:6];
  assign funct  = ir_q[5:0];
  assign imm_sx = {{16{ir_q[15]}}, ir_q[15:0]};

  assign opa = alu_a_sel ? a_q : pc_q;

  always_comb begin
    case (alu_b_sel)
      2'd0:    opb = b_q;
      2'd1:    opb = 32'd4;
      2'd2:    opb = imm_sx;
      default: opb = {imm_sx[29:0], 2'b00};
    endcase
  end

  always_comb begin
    alu_y = opa + opb;
    if (alu_op == 2'd1) alu_y = opa - opb;
    else if (alu_op == 2'd2) begin
      case (funct)
        6'h22:   alu_y = opa - opb;
        6'h24:   alu_y = opa & opb;
        6'h25:   alu_y = opa | opb;
        6'h27:   alu_y = ~(opa | opb);
        6'h2a:   alu_y = {31'b0, $signed(opa) < $signed(opb)};
        6'h00:   alu_y = opb << shamt;
        default: alu_y = opa + opb;
      endcase
    end
  end

  assign alu_zero = (alu_y == 32'd0);
  assign pc_en    = pc_wr | (pc_wr_cond & alu_zero);

  always_comb begin
    case (pc_src)
      2'd0:    pc_next = alu_y;
      2'd1:    pc_next = tgt_q;
      2'd2:    pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_next = aluout_q;
    endcase
  end

  assign wa = dst_sel ? rd : rt;
  assign wd = wb_sel ? mdr_q : aluout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      tgt_q    <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_next;
      if (ir_wr)  ir_q  <= mem_rdata;
      if (tgt_wr) tgt_q <= alu_y;
      mdr_q    <= mem_rdata;
      aluout_q <= alu_y;
      a_q      <= (rs == 5'd0) ? 32'd0 : rf[rs];
      b_q      <= (rt == 5'd0) ? 32'd0 : rf[rt];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (rf_we && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end

  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = mem_wr;

endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_wr,
  input logic        pc_wr_cond,
  input logic        tgt_wr,
  input logic        ir_wr,
  input logic        alu_a_sel,
  input logic [1:0]  alu_b_sel,
  input logic [1:0]  alu_op,
  input logic [1:0]  pc_src,
  input logic        alu_zero,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] tgt,
  input logic [31:0] a
);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc)); // R2

  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd0 && !alu_a_sel && alu_b_sel == 2'd1 && alu_op == 2'd0)
    |=> pc == $past(pc) + 32'd4); // R2

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_wr |=> $stable(ir)); // R2

  AST_R0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ir[25:21] == 5'd0) |=> a == 32'd0); // R6

  AST_BEQ_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && !alu_zero) |=> $stable(pc)); // R7

  AST_BEQ_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr_cond && !pc_wr && alu_zero && pc_src == 2'd1) |=> pc == $past(tgt)); // R7

  AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd2) |=> pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00}); // R8

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_wr |=> $stable(tgt)); // R9

endmodule

bind mc_datapath mc_datapath_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .tgt_wr(tgt_wr), .ir_wr(ir_wr), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
  .alu_op(alu_op), .pc_src(pc_src), .alu_zero(alu_zero), .pc(pc_q),
  .ir(ir_q), .tgt(tgt_q), .a(a_q)
);

// File: tb/tb_mc_datapath.sv
`timescale 1ns/1ps
module tb_mc_datapath;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pc_wr, pc_wr_cond, tgt_wr, ir_wr, addr_sel, mem_wr, rf_we, dst_sel, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_we;

  logic [31:0] dmem [64];
  logic [31:0] instr = '0;
  logic fetching = 1'b0;
  logic [31:0] exp_pc = '0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  mc_datapath dut (.*);

  assign mem_rdata = fetching ? instr : dmem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) dmem[mem_addr[7:2]] <= mem_wdata;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {pc_wr, pc_wr_cond, tgt_wr, ir_wr, addr_sel, mem_wr, rf_we, dst_sel, wb_sel, alu_a_sel} = '0;
    alu_b_sel = 2'd0; alu_op = 2'd0; pc_src = 2'd0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] w);
    idle(); ir_wr = 1; alu_b_sel = 2'd1; pc_wr = 1; fetching = 1; instr = w;
    #1 check("R2 fetch address", mem_addr, exp_pc);
    step(); fetching = 0; exp_pc = exp_pc + 32'd4;
  endtask

  task automatic decode(input logic tw);
    idle(); alu_b_sel = 2'd3; tgt_wr = tw; step();
  endtask

  task automatic addr_calc();
    idle(); alu_a_sel = 1; alu_b_sel = 2'd2; step();
  endtask

  task automatic check_pc(input string tag);
    idle(); #1 check(tag, mem_addr, exp_pc);
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
    fetch(enc_i(6'h23, rs, rt, imm)); decode(1); addr_calc();
    idle(); addr_sel = 1; step();
    idle(); rf_we = 1; wb_sel = 1; step();
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
    fetch(enc_i(6'h2b, rs, rt, imm)); decode(1); addr_calc();
    idle(); addr_sel = 1; mem_wr = 1; step();
  endtask

  task automatic do_r(input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt, input logic [5:0] f, input logic [4:0] sh);
    fetch({6'h00, rs, rt, rd, sh, f}); decode(1);
    idle(); alu_a_sel = 1; alu_op = 2'd2; step();
    idle(); rf_we = 1; dst_sel = 1; step();
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm, input logic taken);
    fetch(enc_i(6'h04, rs, rt, imm)); decode(1);
    idle(); alu_a_sel = 1; alu_op = 2'd1; pc_wr_cond = 1; pc_src = 2'd1; step();
    if (taken) exp_pc = exp_pc + ({{16{imm[15]}}, imm} << 2);
  endtask

  task automatic do_j(input logic [25:0] idx);
    fetch({6'h02, idx}); decode(1);
    idle(); pc_wr = 1; pc_src = 2'd2; step();
    exp_pc = {exp_pc[31:28], idx, 2'b00};
  endtask

  function automatic logic [31:0] ref_alu(input logic [5:0] f, input logic [31:0] x, input logic [31:0] y, input logic [4:0] sh);
    case (f)
      6'h20: return x + y;
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      6'h27: return ~(x | y);
      6'h2a: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return y << sh;
    endcase
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] vals [6];
    logic [5:0] fl [7];
    logic [31:0] tgt_a, keep;
    vals = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h12345678};
    fl = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h27, 6'h2a, 6'h00};
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    idle();
    repeat (3) step();
    #1 check("R1 reset pc", mem_addr, 32'h0);
    check("R1 reset mem_we", {31'b0, mem_we}, 32'h0);
    rst_n = 1;
    step();
    check_pc("R1 pc after reset");

    for (int i = 0; i < 6; i++) begin
      dmem[32+i] = vals[i];
      do_lw(5'(10+i), 5'd0, 16'((32+i)*4));
    end
    for (int i = 0; i < 6; i++) begin
      do_sw(5'(10+i), 5'd0, 16'((40+i)*4));
      check("R3 R4 load then store", dmem[40+i], vals[i]);
    end

    dmem[50] = 32'd128; dmem[30] = 32'hcafef00d;
    do_lw(5'd5, 5'd0, 16'd200);
    do_lw(5'd6, 5'd5, 16'hfff8);
    do_sw(5'd6, 5'd5, 16'hfffc);
    check("R3 R4 negative offset", dmem[31], 32'hcafef00d);

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 7; k++) begin
          do_r(5'd20, 5'(10+i), 5'(10+j), fl[k], 5'(j*5));
          do_sw(5'd20, 5'd0, 16'd64);
          check($sformatf("R5 funct %02h op %0d,%0d", fl[k], i, j), dmem[16],
                ref_alu(fl[k], vals[i], vals[j], 5'(j*5)));
        end

    do_r(5'd0, 5'd15, 5'd15, 6'h20, 5'd0);
    do_sw(5'd0, 5'd0, 16'd68);
    check("R6 r0 after alu write", dmem[17], 32'h0);
    do_lw(5'd0, 5'd0, 16'd140);
    do_sw(5'd0, 5'd0, 16'd72);
    check("R6 r0 after load", dmem[18], 32'h0);

    do_beq(5'd11, 5'd11, 16'd12, 1'b1);
    check_pc("R7 forward taken");
    do_beq(5'd11, 5'd12, 16'd12, 1'b0);
    check_pc("R7 not taken");
    do_beq(5'd13, 5'd13, 16'hfffd, 1'b1);
    check_pc("R7 backward taken");
    do_beq(5'd0, 5'd10, 16'd40, 1'b1);
    check_pc("R7 equal zero regs");
    do_beq(5'd0, 5'd0, 16'h8000, 1'b1);
    check_pc("R7 most negative wrap");

    do_j(26'h123_4567);
    check_pc("R8 jump keeps upper bits");
    check("R8 upper nibble", {28'h0, exp_pc[31:28]}, 32'hf);
    do_j(26'h000_0040);
    check_pc("R8 second jump");

    tgt_a = exp_pc + 32'd4 + 32'd64;
    fetch(enc_i(6'h04, 5'd10, 5'd10, 16'd16)); decode(1);
    fetch(enc_i(6'h04, 5'd10, 5'd10, 16'd100)); decode(0);
    idle(); alu_a_sel = 1; alu_op = 2'd1; pc_wr_cond = 1; pc_src = 2'd1; step();
    exp_pc = tgt_a;
    check_pc("R9 target held when write disabled");

    fetch(enc_i(6'h04, 5'd1, 5'd2, 16'd5)); decode(0);
    idle(); pc_wr = 1; pc_src = 2'd3; step();
    exp_pc = exp_pc + 32'd20;
    check_pc("R11 pc from registered alu");

    dmem[20] = 32'haaaa5555; keep = dmem[20];
    fetch(enc_i(6'h2b, 5'd0, 5'd15, 16'd80)); decode(1); addr_calc();
    idle(); addr_sel = 1;
    #1 check("R10 mem_we low", {31'b0, mem_we}, 32'h0);
    step();
    check("R10 word untouched", dmem[20], keep);
    do_sw(5'd15, 5'd0, 16'd80);
    check("R10 R4 store after hold", dmem[20], vals[5]);

    finish_up();
  end

endmodule